// File: doc/BRIEF.md
# Base Address Register Bank with Size Discovery

This block holds the base address registers of one device function, up to six of them. Each register maps either an I/O port region or a memory region. The region's size is a power of two from 16 bytes to 2 GB and is fixed by a parameter. Its type and its prefetch flag are also fixed by parameters. Configuration software reaches the registers through a 32-bit write/read port that selects a register by its index. Address bits below the region size are hardwired to zero. Because of this, writing all ones and reading the register back returns the region size in encoded form. An ordinary write keeps only the address bits that natural alignment allows.

For every incoming transaction address, the block also raises one hit line per register. A hit needs four things: the address falls inside that register's naturally aligned region, the decode enable for that region type is on, the transaction type matches, and software has written the register since reset. A freshly reset function therefore decodes nothing.

Top module: `bar_bank`

## Requirements
- R1: After reset every implemented register reads back its type flags with all address bits zero, and no hit line is raised.
- R2: After all ones are written to an implemented register of size 2^k, it reads back 0xFFFFFFFF with bits [k-1:0] cleared, ORed with its type flags.
- R3: An ordinary write stores bits [31:k] of the written word. Bits [k-1:0] of the write are dropped, and the read-back shows them as zero apart from the flags.
- R4: Read-back bit 0 is 1 for an I/O register and 0 for a memory register. An I/O register reads bits [3:1] as 000. A memory register reads bits [2:1] as 00 (a 32-bit region) and bit 3 as its prefetch flag.
- R5: An index whose register is not implemented reads as 0, and a write to it has no effect. This covers a cleared bit in the implement mask and the indices 6 and 7.
- R6: Hit line i is 1 exactly when (address AND NOT(size-1)) equals the stored base of register i, the transaction type bit matches (1 = I/O), register i is implemented and written since reset, and its decode enable is on.
- R7: A register that has not been written since reset never raises its hit line, even for an address equal to its reset base of 0.
- R8: A configuration write takes effect at the next rising clock edge. During the cycle of the write, the hit lines and the read-back still reflect the previous base.
- R9: With the memory decode enable off, no memory register hits. With the I/O decode enable off, no I/O register hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Register index for the read and the write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected register (combinational) |
| mem_dec_en | input | 1 | Memory region decode enable |
| io_dec_en | input | 1 | I/O region decode enable |
| txn_addr | input | 32 | Address of the incoming transaction |
| txn_is_io | input | 1 | Transaction type, 1 = I/O, 0 = memory |
| hit_vec | output | NUM_BARS | One hit line per register |

## Verification
A configuration write that moves a base and a transaction that decodes against that same register can fall in the same cycle. The bench provokes this by raising the write strobe for a register that has just been programmed, while it drives an address inside the old region. It expects the hit line to stay high before the edge. After the edge it expects that line to drop for the old address and to rise for an address in the new region. Random stimulus also mixes writes, reads and address probes. Each outcome is judged against a model built from the size, type and enable rules.

// File: rtl/bar_pkg.sv
package bar_pkg;
    localparam int unsigned MAX_BARS  = 6;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned SZ_FIELD_W = 5;

    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic              assigned;
    } bar_state_t;
endpackage

// File: rtl/bar_slot.sv
module bar_slot
    import bar_pkg::*;
#(
    parameter int unsigned SIZE_LOG2 = 12,
    parameter bit          IS_IO     = 1'b0,
    parameter bit          PREFETCH  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mem_en,
    input  logic              io_en,
    input  logic [DATA_W-1:0] addr,
    input  logic              addr_is_io,
    output logic [DATA_W-1:0] rd_o,
    output logic              hit_o
);
    localparam logic [DATA_W-1:0] ADDR_MASK = {DATA_W{1'b1}} << SIZE_LOG2;
    localparam logic [3:0] FLAGS = IS_IO ? 4'h1 : (PREFETCH ? 4'h8 : 4'h0);

    bar_state_t state_d, state_q;
    logic       dec_en_d;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.base     = wdata & ADDR_MASK;
            state_d.assigned = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        dec_en_d = IS_IO ? io_en : mem_en;
        rd_o     = state_q.base | {{(DATA_W-4){1'b0}}, FLAGS};
        hit_o    = state_q.assigned && dec_en_d && (addr_is_io == IS_IO)
                   && ((addr & ADDR_MASK) == state_q.base);
    end

    // R3
    wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_o & ADDR_MASK) == ($past(wdata) & ADDR_MASK));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_o));

    // R7
    unassigned_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.assigned |-> !hit_o);

    // R9
    dec_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (IS_IO ? io_en : mem_en));
endmodule

// File: rtl/bar_rd_mux.sv
module bar_rd_mux
    import bar_pkg::*;
#(
    parameter int unsigned NUM_BARS = 6,
    parameter int unsigned IDX_W    = 3
) (
    input  logic [NUM_BARS*DATA_W-1:0] rd_all,
    input  logic [IDX_W-1:0]           idx,
    output logic [DATA_W-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < int'(NUM_BARS); i++) begin
            if (int'(idx) == i) begin
                rdata = rd_all[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/bar_bank.sv
module bar_bank
    import bar_pkg::*;
#(
    parameter int unsigned NUM_BARS     = 6,
    parameter logic [5:0]  IMPL_MASK    = 6'b110111,
    parameter logic [5:0]  IO_MASK      = 6'b000100,
    parameter logic [5:0]  PREF_MASK    = 6'b100010,
    parameter logic [29:0] SIZE_LOG2_VEC = {5'd31, 5'd4, 5'd4, 5'd8, 5'd20, 5'd12}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [2:0]          cfg_idx,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                mem_dec_en,
    input  logic                io_dec_en,
    input  logic [31:0]         txn_addr,
    input  logic                txn_is_io,
    output logic [NUM_BARS-1:0] hit_vec
);
    localparam int unsigned IDX_W = 3;

    logic [NUM_BARS*DATA_W-1:0] rd_all;

    for (genvar i = 0; i < int'(NUM_BARS); i++) begin : g_bar
        if (IMPL_MASK[i]) begin : g_impl
            logic wr_sel;
            assign wr_sel = cfg_wr_en && (int'(cfg_idx) == i);
            bar_slot #(
                .SIZE_LOG2 (int'(SIZE_LOG2_VEC[i*SZ_FIELD_W +: SZ_FIELD_W])),
                .IS_IO     (IO_MASK[i]),
                .PREFETCH  (PREF_MASK[i])
            ) i_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (wr_sel),
                .wdata      (cfg_wdata),
                .mem_en     (mem_dec_en),
                .io_en      (io_dec_en),
                .addr       (txn_addr),
                .addr_is_io (txn_is_io),
                .rd_o       (rd_all[i*DATA_W +: DATA_W]),
                .hit_o      (hit_vec[i])
            );
        end else begin : g_absent
            assign rd_all[i*DATA_W +: DATA_W] = '0;
            assign hit_vec[i] = 1'b0;
        end
    end

    bar_rd_mux #(
        .NUM_BARS (NUM_BARS),
        .IDX_W    (IDX_W)
    ) i_rd_mux (
        .rd_all (rd_all),
        .idx    (cfg_idx),
        .rdata  (cfg_rdata)
    );

    // R5
    unimpl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_idx) >= int'(NUM_BARS)) |-> (cfg_rdata == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hit_vec == '0));
endmodule

// File: tb/test_bar_bank.sv
`timescale 1ns/1ps
module test_bar_bank;
    localparam logic [5:0] T_IMPL = 6'b110111;
    localparam logic [5:0] T_IO   = 6'b000100;
    localparam logic [5:0] T_PREF = 6'b100010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_dec_en = 1'b1;
    logic        io_dec_en = 1'b1;
    logic [31:0] txn_addr = '0;
    logic        txn_is_io = 1'b0;
    logic [5:0]  hit_vec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] m_base [6];
    bit          m_asg  [6];

    always #2.5 clk = ~clk;

    bar_bank #(
        .NUM_BARS(6), .IMPL_MASK(T_IMPL), .IO_MASK(T_IO), .PREF_MASK(T_PREF),
        .SIZE_LOG2_VEC({5'd31, 5'd4, 5'd4, 5'd8, 5'd20, 5'd12})
    ) i_bar_bank (.*);

    function automatic int szl(int i);
        case (i)
            0: return 12; 1: return 20; 2: return 8;
            4: return 4;  5: return 31; default: return 4;
        endcase
    endfunction

    function automatic logic [31:0] amask(int i);
        return 32'hFFFF_FFFF << szl(i);
    endfunction

    function automatic logic [31:0] flags(int i);
        if (T_IO[i]) return 32'h1;
        return T_PREF[i] ? 32'h8 : 32'h0;
    endfunction

    function automatic logic [31:0] exp_rd(int i);
        if (i > 5 || !T_IMPL[i]) return 32'h0;
        return m_base[i] | flags(i);
    endfunction

    function automatic logic [5:0] exp_hit(logic [31:0] a, logic io);
        logic [5:0] h = '0;
        for (int i = 0; i < 6; i++) begin
            h[i] = T_IMPL[i] && m_asg[i] && (io == T_IO[i])
                   && (T_IO[i] ? io_dec_en : mem_dec_en)
                   && ((a & amask(i)) == m_base[i]);
        end
        return h;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(int idx, logic [31:0] d);
        @(negedge clk);
        cfg_idx = idx[2:0];
        cfg_wdata = d;
        cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (idx < 6 && T_IMPL[idx]) begin
            m_base[idx] = d & amask(idx);
            m_asg[idx] = 1'b1;
        end
    endtask

    task automatic cfg_rd(string req, int idx);
        @(negedge clk);
        cfg_idx = idx[2:0];
        #1;
        chk(req, cfg_rdata, exp_rd(idx));
    endtask

    task automatic probe(string req, logic [31:0] a, logic io);
        txn_addr = a;
        txn_is_io = io;
        #1;
        chk(req, {26'b0, hit_vec}, {26'b0, exp_hit(a, io)});
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin
            m_base[i] = '0;
            m_asg[i] = 1'b0;
        end
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R4 / R5: reset read-back, flags, absent indices
        for (int i = 0; i < 8; i++) cfg_rd("R1_R4_R5 reset read", i);
        // R1 / R7: no hits on base 0 before any write
        probe("R1_R7 reset mem probe", 32'h0, 1'b0);
        probe("R7 reset io probe", 32'h0, 1'b1);
        chk("R7 nothing hits", {26'b0, hit_vec}, 32'h0);

        // R2: sizing of every index
        for (int i = 0; i < 8; i++) begin
            cfg_wr(i, 32'hFFFF_FFFF);
            cfg_rd("R2 sizing read", i);
        end
        cfg_idx = 3'd0; #1;
        chk("R2 4KB memory size code", cfg_rdata, 32'hFFFF_F000);
        cfg_idx = 3'd2; #1;
        chk("R2_R4 256B io size code", cfg_rdata, 32'hFFFF_FF01);
        cfg_idx = 3'd5; #1;
        chk("R2_R4 2GB prefetch size code", cfg_rdata, 32'h8000_0008);

        // R3: low bits dropped
        cfg_wr(1, 32'h1234_5678);
        cfg_idx = 3'd1; #1;
        chk("R3 1MB base keeps [31:20]", cfg_rdata, 32'h1230_0008);
        cfg_wr(4, 32'hABCD_EF17);
        cfg_idx = 3'd4; #1;
        chk("R3 16B base keeps [31:4]", cfg_rdata, 32'hABCD_EF10);

        // R5: write to absent index 3 has no effect
        cfg_wr(3, 32'h5555_0000);
        cfg_rd("R5 absent index stays zero", 3);
        probe("R5 absent no hit", 32'h5555_0000, 1'b0);

        // R6: directed hits at region edges
        cfg_wr(0, 32'h4000_0000);
        cfg_wr(2, 32'h0000_C000);
        probe("R6 mem hit first byte", 32'h4000_0000, 1'b0);
        probe("R6 mem hit last byte", 32'h4000_0FFF, 1'b0);
        probe("R6 mem miss past end", 32'h4000_1000, 1'b0);
        chk("R6 past end no hit bit0", {31'b0, hit_vec[0]}, 32'h0);
        probe("R6 io hit", 32'h0000_C0FF, 1'b1);
        probe("R6 io region as memory misses", 32'h0000_C010, 1'b0);

        // R9: decode enables
        mem_dec_en = 1'b0;
        probe("R9 mem disabled", 32'h4000_0010, 1'b0);
        io_dec_en = 1'b0;
        probe("R9 io disabled", 32'h0000_C010, 1'b1);
        mem_dec_en = 1'b1;
        io_dec_en = 1'b1;

        // R8: write and decode in the same cycle
        @(negedge clk);
        txn_addr = 32'h4000_0020;
        txn_is_io = 1'b0;
        cfg_idx = 3'd0;
        cfg_wdata = 32'h7000_0000;
        cfg_wr_en = 1'b1;
        #1;
        chk("R8 old base still hits during write", {31'b0, hit_vec[0]}, 32'h1);
        chk("R8 old read-back during write", cfg_rdata, 32'h4000_0000);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_base[0] = 32'h7000_0000;
        #1;
        chk("R8 old address misses after edge", {31'b0, hit_vec[0]}, 32'h0);
        probe("R8 new base hits", 32'h7000_0ABC, 1'b0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int idx = int'($urandom % 8);
            int op = int'($urandom % 4);
            if (op == 0) begin
                cfg_wr(idx, $urandom);
            end else if (op == 1) begin
                cfg_rd("R3 random read", idx);
            end else begin
                logic [31:0] a;
                int j = (idx > 5) ? 0 : idx;
                @(negedge clk);
                mem_dec_en = ($urandom % 8) != 0;
                io_dec_en = ($urandom % 8) != 0;
                a = (op == 2) ? (m_base[j] | ($urandom & ~amask(j))) : $urandom;
                probe("R6_R9 random probe", a, (op == 2) ? T_IO[j] : 1'($urandom));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule